// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address when the translation cache misses. It reads the page tables from memory one word at a time. The top 10 virtual bits index a page directory. The current process's directory base register supplies the directory's location. If the directory entry is valid and points to an inner table, the next 10 bits index that table. The entry read there gives the 4 KB frame, and the low 12 bits pass through unchanged as the page offset.

A directory entry with its large-page bit set ends the walk after the first read. Its top 10 bits name a 4 MB frame, and the low 22 virtual bits become the offset. If either entry has its valid bit clear, the walk stops at once and reports a fault together with the level that failed. Each read is held until memory acknowledges it, so any memory latency works. The walker takes a new request only while it is idle.

All entries share one format. Bit 0 is valid. Bit 7 is large-page, and it is looked at only in directory entries. Bits 31:12 hold the base of the next table or frame.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req`, `rsp_done` and `rsp_fault` are 0.
- R2: The first read goes to `{dir_base[31:12], 12'h000} + vaddr[31:22]*4`. The low 12 bits of `dir_base` have no effect.
- R3: When the directory entry is valid (bit 0 = 1) and bit 7 = 0, the second read goes to `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: When the table entry is valid, `rsp_done` pulses for one cycle with `rsp_paddr = {pte[31:12], vaddr[11:0]}`.
- R5: When the directory entry is valid with bit 7 = 1, the walk makes exactly one read and returns `rsp_paddr = {dir_entry[31:22], vaddr[21:0]}`.
- R6: When the directory entry has bit 0 = 0, `rsp_fault` pulses with `rsp_fault_lvl` = 0 (directory) after exactly one read. This holds whatever bit 7 is.
- R7: When the table entry has bit 0 = 0, `rsp_fault` pulses with `rsp_fault_lvl` = 1 (table) after exactly two reads.
- R8: Once `mem_req` is raised, it stays high with a stable `mem_addr` until `mem_ack` is seen. Any number of wait cycles is accepted.
- R9: While `req_ready` is 0, `req_valid` is ignored and produces no extra walk or response. `mem_req` is never high while `req_ready` is 1.
- R10: `rsp_done` and `rsp_fault` are never high together. Each lasts one cycle, and `req_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a walk (taken only when `req_ready` is 1) |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| req_ready | output | 1 | Walker is idle and will take a request |
| mem_req | output | 1 | Word read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_done | output | 1 | One-cycle pulse: translation succeeded |
| rsp_fault | output | 1 | One-cycle pulse: invalid entry found |
| rsp_fault_lvl | output | 1 | Faulting level: 0 directory, 1 table |
| rsp_paddr | output | 32 | Physical address, meaningful with `rsp_done` |

## Verification
The properties assume memory raises `mem_ack` only while `mem_req` is high, and for a single cycle per read. They also assume `req_vaddr` and `dir_base` are stable in the cycle `req_valid` is sampled.

The bench's memory model follows both rules. It acknowledges after a programmable wait, drops `mem_ack` on the next cycle, and answers only an outstanding read. The driver changes request inputs only at the falling edge. The one deliberate breach of the handshake is a `req_valid` pulse sent while a walk is in progress, which is the stimulus for the ignored-request case.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W   = 32;
  localparam int IDX_W  = 10;
  localparam int OFF_W  = 12;
  localparam int ENT_LG = 2;
  localparam int V_BIT  = 0;
  localparam int LG_BIT = 7;
  localparam int FRM_W  = VA_W - OFF_W;
  localparam int LOFF_W = IDX_W + OFF_W;
  localparam int LFRM_W = VA_W - LOFF_W;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIR   = 3'd1,
    ST_PTE   = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_st_t;
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     mem_ack,
  input  logic     ent_valid,
  input  logic     ent_large,
  output walk_st_t st,
  output logic     accept,
  output logic     dir_ack,
  output logic     pte_ack
);
  walk_st_t st_nxt;

  assign accept  = (st == ST_IDLE) && req_valid;
  assign dir_ack = (st == ST_DIR) && mem_ack;
  assign pte_ack = (st == ST_PTE) && mem_ack;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (req_valid) st_nxt = ST_DIR;
      ST_DIR: begin
        if (mem_ack) begin
          if (!ent_valid)     st_nxt = ST_FAULT;
          else if (ent_large) st_nxt = ST_DONE;
          else                st_nxt = ST_PTE;
        end
      end
      ST_PTE: if (mem_ack) st_nxt = ent_valid ? ST_DONE : ST_FAULT;
      ST_DONE, ST_FAULT: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  walk_st_t         st,
  input  logic             accept,
  input  logic             dir_ack,
  input  logic             pte_ack,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [FRM_W-1:0] base_in,
  input  logic [VA_W-1:0]  rdata,
  output logic [VA_W-1:0]  mem_addr,
  output logic [VA_W-1:0]  paddr,
  output logic             fault_lvl
);
  logic [VA_W-1:0]  va_q;
  logic [FRM_W-1:0] base_q;
  logic [FRM_W-1:0] tbl_q;
  logic [IDX_W-1:0] idx_sel;
  logic [FRM_W-1:0] frm_sel;
  logic             ent_v;
  logic             ent_lg;
  logic [IDX_W-1:0] unused_bits;

  assign ent_v  = rdata[V_BIT];
  assign ent_lg = rdata[LG_BIT];
  assign unused_bits = rdata[OFF_W-1:OFF_W-IDX_W];

  // Level select: directory index from the top field, table index below it
  always_comb begin
    if (st == ST_PTE) begin
      idx_sel = va_q[LOFF_W-1:OFF_W];
      frm_sel = tbl_q;
    end else begin
      idx_sel = va_q[VA_W-1:LOFF_W];
      frm_sel = base_q;
    end
  end

  assign mem_addr = {frm_sel, {OFF_W{1'b0}}}
                  + {{(VA_W-IDX_W-ENT_LG){1'b0}}, idx_sel, {ENT_LG{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
    end else if (accept) begin
      va_q   <= req_vaddr;
      base_q <= base_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             tbl_q <= '0;
    else if (dir_ack && ent_v && !ent_lg)   tbl_q <= rdata[VA_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr     <= '0;
      fault_lvl <= 1'b0;
    end else if (dir_ack) begin
      if (!ent_v)      fault_lvl <= 1'b0;
      else if (ent_lg) paddr <= {rdata[VA_W-1:LOFF_W], va_q[LOFF_W-1:0]};
    end else if (pte_ack) begin
      if (!ent_v) fault_lvl <= 1'b1;
      else        paddr <= {rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] dir_base,
  output logic            req_ready,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            rsp_done,
  output logic            rsp_fault,
  output logic            rsp_fault_lvl,
  output logic [VA_W-1:0] rsp_paddr
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  walk_st_t         st;
  logic             accept;
  logic             dir_ack;
  logic             pte_ack;
  logic [OFF_W-1:0] unused_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];
  assign unused_base = dir_base[OFF_W-1:0];

  pgwalk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i),
    .req_valid (req_valid),
    .mem_ack   (mem_ack),
    .ent_valid (mem_rdata[V_BIT]),
    .ent_large (mem_rdata[LG_BIT]),
    .st        (st),
    .accept    (accept),
    .dir_ack   (dir_ack),
    .pte_ack   (pte_ack)
  );

  pgwalk_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_i),
    .st        (st),
    .accept    (accept),
    .dir_ack   (dir_ack),
    .pte_ack   (pte_ack),
    .req_vaddr (req_vaddr),
    .base_in   (dir_base[VA_W-1:OFF_W]),
    .rdata     (mem_rdata),
    .mem_addr  (mem_addr),
    .paddr     (rsp_paddr),
    .fault_lvl (rsp_fault_lvl)
  );

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st == ST_DIR) || (st == ST_PTE);
  assign rsp_done  = (st == ST_DONE);
  assign rsp_fault = (st == ST_FAULT);
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        rsp_done,
  input logic        rsp_fault
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  assert_rsp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_fault));

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_fault) |=> !(rsp_done || rsp_fault));

  assert_rsp_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_fault) |=> req_ready);
endmodule

bind pgwalk_top pgwalk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .rsp_done  (rsp_done),
  .rsp_fault (rsp_fault)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [31:0] dir_base;
  logic        req_ready;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        rsp_done;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic [31:0] rsp_paddr;

  typedef struct {
    logic        fault;
    logic        lvl;
    logic [31:0] paddr;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mem [logic [31:0]];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          lat     = 0;
  int          wcnt    = 0;
  int          reads   = 0;
  logic [31:0] first_addr;
  bit          finished = 0;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .dir_base(dir_base), .req_ready(req_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .rsp_paddr(rsp_paddr)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Expected result from the entry format: bit0 valid, bit7 large, 31:12 base
  function automatic exp_t predict(input logic [31:0] va, input logic [31:0] base,
                                   input string tag);
    exp_t e;
    logic [31:0] d, p;
    e.tag = tag; e.fault = 0; e.lvl = 0; e.paddr = 0;
    d = rd({base[31:12], 12'h000} + {20'h0, va[31:22], 2'b00});
    e.reads = 1;
    if (!d[0]) begin
      e.fault = 1; e.lvl = 0;
    end else if (d[7]) begin
      e.paddr = {d[31:22], va[21:0]};
    end else begin
      p = rd({d[31:12], 12'h000} + {20'h0, va[21:12], 2'b00});
      e.reads = 2;
      if (!p[0]) begin e.fault = 1; e.lvl = 1; end
      else e.paddr = {p[31:12], va[11:0]};
    end
    return e;
  endfunction

  task automatic send(input logic [31:0] va, input logic [31:0] base, input string tag);
    while (!req_ready) @(negedge clk);
    sb.push_back(predict(va, base, tag));
    req_valid = 1; req_vaddr = va; dir_base = base;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic poke_busy(input logic [31:0] va);
    while (req_ready) @(negedge clk);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Memory model plus response monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 0; wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == 0) first_addr = mem_addr;
        if (wcnt >= lat) begin
          n_tests++;
          if (mem_addr !== first_addr) begin
            n_fail++;
            $display("FAIL R8 addr moved: got %h exp %h", mem_addr, first_addr);
          end
          mem_ack = 1; mem_rdata = rd(mem_addr); reads++;
        end else wcnt++;
      end
      if (rsp_done || rsp_fault) begin
        if (sb.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R9 unexpected response: done=%b fault=%b exp none", rsp_done, rsp_fault);
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_tests++;
          if (rsp_fault !== e.fault || rsp_done === e.fault ||
              (e.fault && rsp_fault_lvl !== e.lvl) || (!e.fault && rsp_paddr !== e.paddr)) begin
            n_fail++;
            $display("FAIL %s: got done=%b fault=%b lvl=%b pa=%h exp fault=%b lvl=%b pa=%h",
                     e.tag, rsp_done, rsp_fault, rsp_fault_lvl, rsp_paddr, e.fault, e.lvl, e.paddr);
          end
          n_tests++;
          if (reads != e.reads) begin
            n_fail++;
            $display("FAIL %s read count: got %0d exp %0d", e.tag, reads, e.reads);
          end
        end
        reads = 0;
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: got timeout exp completion");
    finish_run();
  end

  localparam logic [31:0] BA = 32'h0001_0000;
  localparam logic [31:0] BB = 32'h0003_0000;

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; dir_base = 0;
    mem_ack = 0; mem_rdata = 0;
    mem[BA + 12]            = 32'h0002_0001;
    mem[32'h0002_0000 + 20] = 32'h0ABC_D001;
    mem[BA + 16]            = 32'h0C40_0081;
    mem[BA + 28]            = 32'h0000_0080;
    mem[BA + 4092]          = 32'hFFC0_0081;
    mem[BB + 0]             = 32'h0004_0001;
    mem[32'h0004_0000 + 4092] = 32'h1234_5001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_tests++;
    if (req_ready !== 1 || mem_req !== 0 || rsp_done !== 0 || rsp_fault !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: got rdy=%b req=%b done=%b flt=%b exp 1 0 0 0",
               req_ready, mem_req, rsp_done, rsp_fault);
    end
    lat = 2; send({10'd3, 10'd5, 12'h123}, BA, "R3/R4 small page");
    lat = 0; send({10'd4, 22'h2A_BCDE}, BA, "R5 large page");
    lat = 1; send({10'd6, 10'd1, 12'h0}, BA, "R6 dir invalid");
    lat = 3; send({10'd7, 10'd1, 12'h0}, BA, "R6 dir invalid with large bit");
    lat = 0; send({10'd3, 10'd9, 12'h7}, BA, "R7 table invalid");
    lat = 5; send({10'd3, 10'd5, 12'hFFF}, BA | 32'h0000_0ABC, "R2 base low bits ignored");
    poke_busy({10'd4, 22'h0});
    lat = 7; send({10'd0, 10'd1023, 12'hFFF}, BB, "R8/R3 long wait, max inner index");
    poke_busy({10'd6, 22'h0});
    lat = 0; send(32'hFFFF_FFFF, BA, "R5 max outer index");
    while (!req_ready || sb.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9 pending: got %0d exp 0", sb.size());
    end
    finish_run();
  end
endmodule